// File: doc/BRIEF.md
# Receive Frame Size Statistics Counters

This block sits beside an Ethernet receive path and keeps per-length histograms of good received frames. The receive logic reports each completed frame on a frame-status strobe. The strobe carries the frame length, counted from the first byte of the destination address up to and including the last byte of the CRC, together with three flags: CRC error, link error, and a flag for a frame dropped because the receive packet buffer overran. A frame with no error and no drop is sorted into a length bucket, and the counter for that bucket advances by one.

Software reads the counters through a small register read port. Every counter is cleared when it is read. An optional counter of buffer-overrun drops sits beside the buckets. It shows that dropped frames are counted as missed and never as sized. The counters stop at their maximum value and do not wrap. A read that arrives in the same cycle as an increment of the same counter loses no event.

Top module: `rx_size_stats`

## Requirements
- R1: After reset every counter holds zero, and `rd_data` is zero until the first read.
- R2: A good frame of 65 to 127 bytes, inclusive, adds one to the small-bucket counter at offset 0x4060. The count is visible to a read issued in the cycle after the status strobe.
- R3: A good frame of 128 to 255 bytes, inclusive, adds one to the large-bucket counter at offset 0x4064.
- R4: A good frame of 64 bytes or less, or of 256 bytes or more, leaves both bucket counters unchanged. At most one bucket counts any frame.
- R5: A frame with `fs_crc_err` or `fs_link_err` set changes no bucket counter.
- R6: A frame with `fs_ovr_drop` set changes no bucket counter, whatever its length. It adds one to the missed-frame counter at offset 0x4010.
- R7: A read (`rd_en` high for one cycle) places the counter value on `rd_data` in the following cycle and clears that counter to zero. `rd_data` holds its value while `rd_en` is low.
- R8: When a read and an increment hit the same counter in the same cycle, the read returns the old value and the counter becomes 1.
- R9: A counter that holds its all-ones value stays there on further increments and does not wrap.
- R10: A read of any offset other than the mapped ones returns zero and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fs_valid | input | 1 | One-cycle strobe: a frame has completed |
| fs_len | input | LEN_W (16) | Frame length in bytes, destination address through CRC |
| fs_crc_err | input | 1 | The frame had a CRC error |
| fs_link_err | input | 1 | The frame had a link error |
| fs_ovr_drop | input | 1 | The frame was dropped because the receive buffer overran |
| rd_en | input | 1 | Register read request, one cycle |
| rd_addr | input | ADDR_W (16) | Byte offset of the register to read |
| rd_data | output | DATA_W (32) | Read result, valid the cycle after `rd_en` |

## Verification
The assertions assume that `fs_len` and the three flags only have meaning while `fs_valid` is high. They also assume that `rd_en` is a single-cycle request whose data is taken on the next cycle. They do not assume that reads and frames are kept apart, so the collision case is a legal input. The stimulus raises the strobe and the read request for exactly one clock each, from the falling edge. It drives lengths on both sides of every bucket edge, sends frames with every error and drop flag, and issues one read in the same cycle as a frame to the same bucket. A narrow instance of the block is used to reach saturation in a short run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Lower bound of length bucket i: the first bucket starts above the
  // minimum frame size, later ones at successive powers of two.
  function automatic int unsigned bucket_lo(input int unsigned idx);
    return (idx == 0) ? 32'd65 : (32'd64 << idx);
  endfunction

  // Upper bound of length bucket i, inclusive.
  function automatic int unsigned bucket_hi(input int unsigned idx);
    return (32'd128 << idx) - 32'd1;
  endfunction

  typedef struct packed {
    logic crc_err;
    logic link_err;
    logic ovr_drop;
  } rfs_flags_t;

endpackage

// File: rtl/rfs_rst_sync.sv
module rfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rfs_classify.sv
module rfs_classify
  import rfs_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int NUM_BKT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_valid,
  input  logic [LEN_W-1:0]   fs_len,
  input  rfs_flags_t         fs_flags,
  output logic [NUM_BKT-1:0] bkt_hit,
  output logic               miss_hit
);
  logic good;

  always_comb begin
    good     = fs_valid && !fs_flags.crc_err && !fs_flags.link_err && !fs_flags.ovr_drop;
    miss_hit = fs_valid && fs_flags.ovr_drop;
  end

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_bkt
    localparam int unsigned LO = bucket_lo(g);
    localparam int unsigned HI = bucket_hi(g);
    logic in_range;
    always_comb begin
      in_range   = (32'(fs_len) >= LO) && (32'(fs_len) <= HI);
      bkt_hit[g] = good && in_range;
    end
  end

  // R4
  bkt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bkt_hit));

  // R5
  bkt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bkt_hit != '0) |-> (fs_valid && !fs_flags.crc_err && !fs_flags.link_err));

  // R6
  drop_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_hit |-> (bkt_hit == '0));
endmodule

// File: rtl/rfs_counter.sv
module rfs_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc || clr;
    cnt_d  = cnt_q;
    if (clr)                    cnt_d = inc ? ONE : '0;
    else if (inc && cnt_q != MAX) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != MAX) |=> (cnt == $past(cnt) + ONE));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt == '0));

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> (cnt == ONE));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MAX) |=> (cnt == MAX));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/rfs_rdmux.sv
module rfs_rdmux #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 32,
  parameter int          NUM_BKT  = 2,
  parameter int unsigned BASE     = 32'h4060,
  parameter int unsigned STRIDE   = 4,
  parameter int unsigned MISS_OFF = 32'h4010,
  parameter bit          HAS_MISS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [CNT_W-1:0]   bkt_cnt [NUM_BKT],
  input  logic [CNT_W-1:0]   miss_cnt,
  output logic [NUM_BKT-1:0] bkt_clr,
  output logic               miss_clr,
  output logic [DATA_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] MISS_A = ADDR_W'(MISS_OFF);

  logic [DATA_W-1:0] bkt_word [NUM_BKT];
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              hit_any;

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(BASE + STRIDE * g);
    always_comb begin
      bkt_clr[g]  = rd_en && (rd_addr == ADDR);
      bkt_word[g] = bkt_clr[g] ? DATA_W'(bkt_cnt[g]) : '0;
    end
  end

  always_comb begin
    miss_clr = HAS_MISS && rd_en && (rd_addr == MISS_A);
    rd_d     = miss_clr ? DATA_W'(miss_cnt) : '0;
    for (int i = 0; i < NUM_BKT; i++) rd_d = rd_d | bkt_word[i];
    hit_any  = miss_clr || (bkt_clr != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_any) |=> (rd_data == '0));

  // R7
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bkt_clr, miss_clr}));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rx_size_stats.sv
module rx_size_stats
  import rfs_pkg::*;
#(
  parameter int          LEN_W    = 16,
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 32,
  parameter int          NUM_BKT  = 2,
  parameter int unsigned BASE     = 32'h4060,
  parameter int unsigned MISS_OFF = 32'h4010,
  parameter bit          HAS_MISS = 1'b1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fs_valid,
  input  logic [LEN_W-1:0]  fs_len,
  input  logic              fs_crc_err,
  input  logic              fs_link_err,
  input  logic              fs_ovr_drop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned STRIDE = DATA_W / 8;

  logic               rst_n;
  rfs_flags_t         flags;
  logic [NUM_BKT-1:0] bkt_hit, bkt_clr;
  logic               miss_hit, miss_clr;
  logic [CNT_W-1:0]   bkt_cnt [NUM_BKT];
  logic [CNT_W-1:0]   miss_cnt;

  assign flags = '{crc_err: fs_crc_err, link_err: fs_link_err, ovr_drop: fs_ovr_drop};

  rfs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  rfs_classify #(.LEN_W(LEN_W), .NUM_BKT(NUM_BKT)) u_cls (
    .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .fs_len(fs_len),
    .fs_flags(flags), .bkt_hit(bkt_hit), .miss_hit(miss_hit)
  );

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_cnt
    rfs_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(bkt_hit[g]), .clr(bkt_clr[g]),
      .cnt(bkt_cnt[g])
    );
  end

  if (HAS_MISS) begin : g_miss
    rfs_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(miss_hit), .clr(miss_clr),
      .cnt(miss_cnt)
    );
  end else begin : g_nomiss
    assign miss_cnt = '0;
  end

  rfs_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_BKT(NUM_BKT),
    .BASE(BASE), .STRIDE(STRIDE), .MISS_OFF(MISS_OFF), .HAS_MISS(HAS_MISS)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .bkt_cnt(bkt_cnt), .miss_cnt(miss_cnt), .bkt_clr(bkt_clr),
    .miss_clr(miss_clr), .rd_data(rd_data)
  );
endmodule

// File: tb/rx_size_stats_bench.sv
`timescale 1ns/1ps
module rx_size_stats_bench;
  localparam logic [15:0] A_SMALL = 16'h4060;
  localparam logic [15:0] A_LARGE = 16'h4064;
  localparam logic [15:0] A_MISS  = 16'h4010;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        fs_valid, fs_crc_err, fs_link_err, fs_ovr_drop;
  logic [15:0] fs_len;
  logic        rd_en, rd_en_n;
  logic [15:0] rd_addr, rd_addr_n;
  logic [31:0] rd_data, rd_data_n;

  exp_t        sb_q[$];
  int unsigned m_small, m_large, m_miss, n_small;
  int          vectors = 0;
  int          errors  = 0;

  always #10 clk = ~clk;

  rx_size_stats u_rx_size_stats (
    .clk(clk), .arst_n(arst_n), .fs_valid(fs_valid), .fs_len(fs_len),
    .fs_crc_err(fs_crc_err), .fs_link_err(fs_link_err), .fs_ovr_drop(fs_ovr_drop),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rx_size_stats #(.CNT_W(4)) u_rx_size_stats_narrow (
    .clk(clk), .arst_n(arst_n), .fs_valid(fs_valid), .fs_len(fs_len),
    .fs_crc_err(fs_crc_err), .fs_link_err(fs_link_err), .fs_ovr_drop(fs_ovr_drop),
    .rd_en(rd_en_n), .rd_addr(rd_addr_n), .rd_data(rd_data_n)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic model_frame(input int unsigned len, input bit crc, input bit lnk, input bit ovr);
    if (ovr) m_miss++;
    if (!crc && !lnk && !ovr) begin
      if (len >= 65 && len <= 127) begin
        m_small++;
        if (n_small < 15) n_small++;
      end else if (len >= 128 && len <= 255) begin
        m_large++;
      end
    end
  endtask

  task automatic model_read(input logic [15:0] addr, input string tag);
    exp_t e;
    e.tag = tag;
    case (addr)
      A_SMALL: begin e.val = m_small; m_small = 0; end
      A_LARGE: begin e.val = m_large; m_large = 0; end
      A_MISS:  begin e.val = m_miss;  m_miss  = 0; end
      default: e.val = 0;
    endcase
    sb_q.push_back(e);
  endtask

  task automatic frame(input int unsigned len, input bit crc = 0, input bit lnk = 0,
                       input bit ovr = 0);
    @(negedge clk);
    fs_valid = 1'b1; fs_len = 16'(len);
    fs_crc_err = crc; fs_link_err = lnk; fs_ovr_drop = ovr;
    model_frame(len, crc, lnk, ovr);
    @(negedge clk);
    fs_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] addr, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    model_read(addr, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Read and frame in the same cycle: the read sees the old value.
  task automatic frame_and_read(input int unsigned len, input logic [15:0] addr,
                                input string tag);
    @(negedge clk);
    fs_valid = 1'b1; fs_len = 16'(len);
    fs_crc_err = 0; fs_link_err = 0; fs_ovr_drop = 0;
    rd_en = 1'b1; rd_addr = addr;
    model_read(addr, tag);
    model_frame(len, 0, 0, 0);
    @(negedge clk);
    fs_valid = 1'b0; rd_en = 1'b0;
  endtask

  // Monitor: compares each read result against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          vectors++; errors++;
          $display("FAIL scoreboard underflow actual=%0h expected=none", rd_data);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(rd_data, e.val, e.tag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0;
    fs_valid = 0; fs_len = 0; fs_crc_err = 0; fs_link_err = 0; fs_ovr_drop = 0;
    rd_en = 0; rd_addr = 0; rd_en_n = 0; rd_addr_n = 0;
    m_small = 0; m_large = 0; m_miss = 0; n_small = 0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rd_data, 32'h0, "R1 rd_data after reset");
    rd(A_SMALL, "R1 small counter after reset");
    rd(A_LARGE, "R1 large counter after reset");
    rd(A_MISS,  "R1 missed counter after reset");

    // R2 R3 R4: bucket edges
    frame(64); frame(65); frame(127); frame(128);
    frame(255); frame(256); frame(1518); frame(40);
    rd(A_SMALL, "R2 R4 small bucket edges 65 and 127");
    rd(A_LARGE, "R3 R4 large bucket edges 128 and 255");
    // R7: cleared by the read
    rd(A_SMALL, "R7 small counter cleared by read");
    rd(A_LARGE, "R7 large counter cleared by read");

    // R5 R6: errored and dropped frames
    frame(100, 1, 0, 0); frame(200, 0, 1, 0); frame(100, 0, 0, 1);
    frame(200, 0, 0, 1); frame(300, 0, 0, 1); frame(90);
    rd(A_SMALL, "R5 R6 small bucket skips bad frames");
    rd(A_LARGE, "R5 R6 large bucket skips bad frames");
    rd(A_MISS,  "R6 missed counter counts drops");

    // R10: unmapped reads
    frame(70); frame(80); frame(150);
    rd(16'h4000, "R10 unmapped 0x4000 reads zero");
    rd(16'h4062, "R10 unmapped 0x4062 reads zero");
    rd(16'h4068, "R10 unmapped 0x4068 reads zero");
    rd(A_SMALL, "R10 small counter untouched by unmapped read");
    rd(A_LARGE, "R10 large counter untouched by unmapped read");

    // R8: read and increment collide
    frame(100); frame(110);
    frame_and_read(120, A_SMALL, "R8 collision read returns old value");
    rd(A_SMALL, "R8 counter holds one after collision");
    frame_and_read(200, A_SMALL, "R8 read of other counter during frame");
    rd(A_LARGE, "R8 other counter still counted");

    // R9: saturation on the 4-bit instance
    for (int i = 0; i < 20; i++) frame(66);
    @(negedge clk);
    rd_en_n = 1'b1; rd_addr_n = A_SMALL;
    @(negedge clk);
    rd_en_n = 1'b0;
    check(rd_data_n, 32'(n_small), "R9 narrow counter saturates at 15");
    rd(A_SMALL, "R2 wide counter keeps counting");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      vectors++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule